// File: doc/BRIEF.md
# Programmable Raster Sync Generator

This block produces the horizontal and vertical timing of a raster display. Two counters track the current pixel within a line and the current line within a frame. From these it drives active-low horizontal and vertical sync, a display-enable flag, and single-cycle event pulses. The pulses mark the start of each line, the start of each frame, and a request to fetch the pixels of the next visible line one line early. The visible area defaults to 800 by 600, clocked by a 50 MHz pixel clock. Sync width and porch widths are not fixed. They arrive as two 32-bit timing words, one per axis, and may be changed while the raster runs.

Each timing word packs four 8-bit widths: the sync width in bits 7:0, the front porch in bits 15:8, the back porch in bits 23:16, and the sum of both porches in bits 31:24. Within a line the order is the visible region, then the front porch, then sync, then the back porch. Frames follow the same order in units of lines. The period is the visible size plus the sync width plus the porch-sum field. The back-porch field is carried for software but is never read. A run input starts the raster. Dropping it stops the raster only at the next line boundary, so the output never breaks off part-way through a line.

Top module: `vga_raster_gen`

## Requirements
- R1: While reset is high and on the cycle after it, pix_x and line_y are 0, hsync_n and vsync_n are 1, and disp_en, line_start, frame_start and line_req are 0.
- R2: With run held high, pix_x steps by one per cycle and wraps to 0 after ACTIVE_W + sync + sum − 1 (fields 7:0 and 31:24 of h_cfg). hsync_n is 0 exactly for pix_x in [ACTIVE_W + front, ACTIVE_W + front + sync), with front taken from field 15:8.
- R3: line_y steps by one when pix_x wraps and wraps to 0 after ACTIVE_H + sync + sum − 1 lines (fields of v_cfg). vsync_n is 0 exactly for line_y in [ACTIVE_H + front, ACTIVE_H + front + sync).
- R4: disp_en is 1 exactly when the raster is running, pix_x < ACTIVE_W and line_y < ACTIVE_H.
- R5: With the default horizontal word (sync 128, front 40, back 88, sum 128) a line lasts ACTIVE_W + 256 cycles. Sync is low for 128 of them, starting at pixel ACTIVE_W + 40.
- R6: line_start is 1 for one cycle when the running raster is at pix_x = 0. frame_start is 1 on the same cycle if line_y is also 0.
- R7: line_req accompanies line_start exactly when the next line is visible, that is when line_y < ACTIVE_H − 1 or line_y is the last line of the frame. This gives ACTIVE_H requests per frame.
- R8: When run drops, the raster finishes its current line and then halts with pix_x = 0 and line_y on the next line. While halted the counters and syncs hold, disp_en is 0, and no event pulse is produced.
- R9: When run rises while halted, the raster is running from the next cycle: line_start pulses then, and pix_x reaches 1 one cycle later.
- R10: The back-porch field (bits 23:16) has no effect on timing. Changing it alone leaves the line length unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Raster enable; a stop takes effect at a line end |
| h_cfg | input | 32 | Horizontal timing word in pixels |
| v_cfg | input | 32 | Vertical timing word in lines |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | Visible pixel flag |
| pix_x | output | CW | Pixel position within the line |
| line_y | output | CW | Line position within the frame |
| line_start | output | 1 | First pixel of a line while running |
| frame_start | output | 1 | First pixel of a frame while running |
| line_req | output | 1 | Fetch request for the next visible line |

## Verification
The hardest state to reach is a stop requested in the middle of a line, where the raster must keep going to the line end and then freeze. The bench drops run at a chosen pixel of a short line. It confirms that the counter still advances on the next cycle, that the raster then comes to rest at pixel 0 of the following line, and that nothing moves or pulses during a long idle stretch. The frame-level checks, covering vertical sync placement and the count of fetch requests, use small bench parameters for the visible area, so that a whole frame fits in a few thousand cycles. The horizontal default widths are kept. A per-cycle model built from the requirements shadows every output throughout the run.

// File: rtl/vga_tim_pkg.sv
package vga_tim_pkg;

    // Packed per-axis timing word: bit positions are fixed by the register layout.
    typedef struct packed {
        logic [7:0] sum;    // front + back porch
        logic [7:0] back;   // back porch (informational)
        logic [7:0] front;  // front porch
        logic [7:0] sync;   // sync width
    } span_t;

    // Counter width large enough for the visible size plus two full 8-bit porches and a sync.
    function automatic int cnt_width(input int active_w, input int active_h);
        int big;
        big = (active_w > active_h) ? active_w : active_h;
        return $clog2(big + 3 * 255 + 1);
    endfunction

endpackage

// File: rtl/vga_run_ctl.sv
module vga_run_ctl (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic line_end,
    output logic running
);
    always_ff @(posedge clk) begin
        if (rst)
            running <= 1'b0;
        else if (running)
            running <= run | ~line_end;
        else
            running <= run;
    end

    // R8: the raster only stops on the last pixel of a line
    p_halt_at_line_end_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(running) |-> $past(line_end));

    // R9: a start request while halted takes effect on the next cycle
    p_resume_next_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !running) |=> running);
endmodule

// File: rtl/vga_axis.sv
module vga_axis
    import vga_tim_pkg::*;
#(
    parameter int ACTIVE = 800,
    parameter int CW     = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    input  span_t         cfg,
    output logic [CW-1:0] cnt,
    output logic          at_last,
    output logic          in_active,
    output logic          in_sync
);
    logic [CW-1:0] last;
    logic [CW-1:0] sync_lo;
    logic [CW-1:0] sync_hi;

    always_comb begin
        last    = CW'(ACTIVE) + CW'(cfg.sync) + CW'(cfg.sum) - CW'(1);
        sync_lo = CW'(ACTIVE) + CW'(cfg.front);
        sync_hi = sync_lo + CW'(cfg.sync);
    end

    assign at_last   = (cnt >= last);
    assign in_active = (cnt < CW'(ACTIVE));
    assign in_sync   = (cnt >= sync_lo) && (cnt < sync_hi);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + CW'(1);
    end

    // R2/R3: a step on the final position returns the counter to zero
    p_wrap_to_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (step && at_last) |=> (cnt == '0));

    // R8: without a step the position is held
    p_hold_no_step_r8: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));
endmodule

// File: rtl/vga_raster_gen.sv
module vga_raster_gen
    import vga_tim_pkg::*;
#(
    parameter int ACTIVE_W = 800,
    parameter int ACTIVE_H = 600,
    localparam int CW = cnt_width(ACTIVE_W, ACTIVE_H)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [31:0]   h_cfg,
    input  logic [31:0]   v_cfg,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          disp_en,
    output logic [CW-1:0] pix_x,
    output logic [CW-1:0] line_y,
    output logic          line_start,
    output logic          frame_start,
    output logic          line_req
);
    span_t h_span, v_span;
    logic  running;
    logic  h_last, v_last, h_act, v_act, h_syn, v_syn;

    assign h_span = span_t'(h_cfg);
    assign v_span = span_t'(v_cfg);

    vga_run_ctl u_ctl (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .line_end (h_last),
        .running  (running)
    );

    vga_axis #(.ACTIVE(ACTIVE_W), .CW(CW)) u_h (
        .clk       (clk),
        .rst       (rst),
        .step      (running),
        .cfg       (h_span),
        .cnt       (pix_x),
        .at_last   (h_last),
        .in_active (h_act),
        .in_sync   (h_syn)
    );

    vga_axis #(.ACTIVE(ACTIVE_H), .CW(CW)) u_v (
        .clk       (clk),
        .rst       (rst),
        .step      (running & h_last),
        .cfg       (v_span),
        .cnt       (line_y),
        .at_last   (v_last),
        .in_active (v_act),
        .in_sync   (v_syn)
    );

    assign hsync_n     = ~h_syn;
    assign vsync_n     = ~v_syn;
    assign disp_en     = running & h_act & v_act;
    assign line_start  = running & (pix_x == '0);
    assign frame_start = line_start & (line_y == '0);
    assign line_req    = line_start & ((line_y < CW'(ACTIVE_H - 1)) | v_last);

    // R4: visible pixels never coincide with either sync pulse
    p_den_outside_sync_r4: assert property (@(posedge clk) disable iff (rst)
        disp_en |-> (hsync_n && vsync_n));

    // R6: a frame start is always also a line start
    p_frame_in_line_r6: assert property (@(posedge clk) disable iff (rst)
        frame_start |-> line_start);

    // R7: no fetch is requested at the last visible line unless it ends the frame
    p_no_req_after_last_r7: assert property (@(posedge clk) disable iff (rst)
        (line_start && line_y == CW'(ACTIVE_H - 1) && !v_last) |-> !line_req);

    // R8: a halted raster emits no events
    p_quiet_when_halted_r8: assert property (@(posedge clk) disable iff (rst)
        !running |-> !(line_start || line_req || disp_en));
endmodule

// File: tb/vga_raster_gen_test.sv
module vga_raster_gen_test;
    localparam int AW = 16;
    localparam int AH = 12;
    localparam int CW = vga_tim_pkg::cnt_width(AW, AH);

    localparam logic [31:0] H_DEF   = 32'h8058_2880; // sum128 back88 front40 sync128
    localparam logic [31:0] H_SMALL = 32'h0201_0102; // sum2 back1 front1 sync2 -> 20
    localparam logic [31:0] H_BACKX = 32'h0277_0102; // back field only changed
    localparam logic [31:0] V_SMALL = 32'h0403_0102; // sum4 back3 front1 sync2 -> 18

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run = 1'b0;
    logic [31:0] h_cfg = H_DEF;
    logic [31:0] v_cfg = V_SMALL;
    logic hsync_n, vsync_n, disp_en, line_start, frame_start, line_req;
    logic [CW-1:0] pix_x, line_y;

    int n_chk = 0;
    int n_fail = 0;
    int mism = 0;
    bit done = 0;

    always #2 clk = ~clk;

    vga_raster_gen #(.ACTIVE_W(AW), .ACTIVE_H(AH)) uut (
        .clk(clk), .rst(rst), .run(run), .h_cfg(h_cfg), .v_cfg(v_cfg),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .disp_en(disp_en),
        .pix_x(pix_x), .line_y(line_y), .line_start(line_start),
        .frame_start(frame_start), .line_req(line_req)
    );

    // Requirement-level shadow model
    int mx = 0, my = 0;
    bit mrun = 0;
    function automatic int hlast();
        return AW + int'(h_cfg[7:0]) + int'(h_cfg[31:24]) - 1;
    endfunction
    function automatic int vlast();
        return AH + int'(v_cfg[7:0]) + int'(v_cfg[31:24]) - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            mx <= 0; my <= 0; mrun <= 0;
        end else begin
            mrun <= mrun ? (run || (mx < hlast())) : run;
            if (mrun) begin
                if (mx >= hlast()) begin
                    mx <= 0;
                    my <= (my >= vlast()) ? 0 : my + 1;
                end else mx <= mx + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            int hl, vl;
            bit ehs, evs, eden, els, efs, elr;
            hl = AW + int'(h_cfg[15:8]);
            vl = AH + int'(v_cfg[15:8]);
            ehs = !(mx >= hl && mx < hl + int'(h_cfg[7:0]));
            evs = !(my >= vl && my < vl + int'(v_cfg[7:0]));
            eden = mrun && mx < AW && my < AH;
            els = mrun && mx == 0;
            efs = els && my == 0;
            elr = els && (my < AH - 1 || my >= vlast());
            if (int'(pix_x) != mx || int'(line_y) != my || hsync_n != ehs ||
                vsync_n != evs || disp_en != eden || line_start != els ||
                frame_start != efs || line_req != elr) begin
                if (mism < 3)
                    $display("model mismatch x=%0d/%0d y=%0d/%0d den=%0b/%0b",
                             pix_x, mx, line_y, my, disp_en, eden);
                mism++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ls();
        do @(negedge clk); while (!line_start);
    endtask

    task automatic t_reset();
        rst = 1'b1; run = 1'b0;
        repeat (3) @(negedge clk);
        check(pix_x == 0 && line_y == 0, "R1 counters in reset", int'(pix_x) + int'(line_y), 0);
        rst = 1'b0;
        @(negedge clk);
        check(hsync_n && vsync_n, "R1 syncs idle high", {hsync_n, vsync_n}, 3);
        check(!(disp_en || line_start || frame_start || line_req), "R1 flags low",
              {disp_en, line_start, frame_start, line_req}, 0);
    endtask

    task automatic t_hline_default();
        int len = 0, lows = 0, first_low = -1;
        h_cfg = H_DEF; v_cfg = V_SMALL;
        run = 1'b1;
        wait_ls();
        do begin
            if (!hsync_n) begin
                if (first_low < 0) first_low = int'(pix_x);
                lows++;
            end
            len++;
            @(negedge clk);
        end while (!line_start);
        check(len == AW + 256, "R5 default line length", len, AW + 256);
        check(lows == 128, "R5 hsync low width", lows, 128);
        check(first_low == AW + 40, "R2 hsync start pixel", first_low, AW + 40);
    endtask

    task automatic t_frame();
        int lines = 0, reqs = 0, vlow = 0, first_v = -1, last_y = 0;
        do @(negedge clk); while (!frame_start);
        do begin
            if (line_start) begin
                lines++;
                if (line_req) reqs++;
                if (!vsync_n) begin
                    if (first_v < 0) first_v = int'(line_y);
                    vlow++;
                end
                last_y = int'(line_y);
            end
            @(negedge clk);
        end while (!frame_start);
        check(lines == AH + 6, "R3 lines per frame", lines, AH + 6);
        check(last_y == AH + 5, "R3 last line index", last_y, AH + 5);
        check(vlow == 2, "R3 vsync low lines", vlow, 2);
        check(first_v == AH + 1, "R3 vsync start line", first_v, AH + 1);
        check(reqs == AH, "R7 fetch requests per frame", reqs, AH);
        check(line_start && line_y == 0, "R6 frame start on line zero", int'(line_y), 0);
    endtask

    task automatic t_stop();
        int y0;
        h_cfg = H_SMALL;
        wait_ls();
        y0 = int'(line_y);
        do @(negedge clk); while (pix_x != 5);
        run = 1'b0;
        @(negedge clk);
        check(pix_x == 6, "R8 line continues after stop", int'(pix_x), 6);
        repeat (14) @(negedge clk);
        check(pix_x == 0, "R8 halts at pixel zero", int'(pix_x), 0);
        check(int'(line_y) == ((y0 + 1) % (AH + 6)), "R8 halts on next line",
              int'(line_y), (y0 + 1) % (AH + 6));
        begin
            bit moved = 0;
            repeat (40) begin
                @(negedge clk);
                if (pix_x != 0 || line_start || line_req || disp_en) moved = 1;
            end
            check(!moved, "R8 frozen while halted", moved, 0);
        end
    endtask

    task automatic t_resume();
        run = 1'b1;
        @(negedge clk);
        check(line_start && pix_x == 0, "R9 line_start on resume", line_start, 1);
        @(negedge clk);
        check(pix_x == 1, "R9 pixel advances", int'(pix_x), 1);
    endtask

    task automatic t_back_field();
        int len = 0;
        h_cfg = H_BACKX;
        wait_ls();
        do begin len++; @(negedge clk); end while (!line_start);
        check(len == AW + 4, "R10 back field ignored", len, AW + 4);
    endtask

    initial begin
        #600000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_hline_default();
        t_frame();
        t_stop();
        t_resume();
        t_back_field();
        check(mism == 0, "R4 per-cycle model agreement", mism, 0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule